// File: doc/BRIEF.md
# Privileged Address Segment Translator

This block turns a 64-bit virtual address into a physical address for the unmapped kernel regions of a 64-bit processor, or reports an address error. Each request carries the address, the kind of access (instruction fetch, data load or data store) and three fields from the processor status register: the exception flag, the error flag and the two-bit operating mode. From these fields the block works out the current privilege level. It decodes which segment the address falls in and checks that level against the level the segment demands.

Only two kinds of region translate. The first is the large physical window selected by the top two address bits. The second is the pair of 32-bit compatibility kernel regions at the top of the address space. Every other segment is mapped and reports an address error, because translation through a TLB is not part of this block. A fault drives the physical address to zero and selects either the load or the store address-error code. An optional output register returns each result one cycle after its request and marks it with a valid strobe.

Top module: `vseg_translator`

## Requirements
- R1: When the exception flag (`st_exl`) or the error flag (`st_erl`) is 1, the current level is Kernel for every value of `st_mode`.
- R2: With both flags at 0, `st_mode` sets the level as follows: 00 gives Kernel, 01 gives Supervisor, 10 gives User, and the reserved value 11 gives User.
- R3: An address with bits 63:62 = 10 is in the physical window. It needs Kernel level and translates to bits 58:0 zero-extended to 64 bits, so bits 61:59 have no effect on the result.
- R4: An address with bits 63:62 = 11, bits 61:31 all ones and bits 30:29 equal to 00 or 01 is in a compatibility kernel region. It needs Kernel level and translates to bits 28:0 zero-extended to 64 bits.
- R5: All other addresses fault at every level. These are the compatibility region with bits 30:29 = 10 or 11, any other address with bits 63:62 = 11, and any address with bits 63:62 = 01 or 00.
- R6: Levels are ordered User (0) < Supervisor (1) < Kernel (2). An access to a translating segment faults when the current level is below the level that segment needs.
- R7: When `fault` is 1, `fault_is_store` is 1 for access code 10 (store) and 0 for codes 00 (fetch), 01 (load) and 11 (treated as a load). When `fault` is 0, `fault_is_store` is 0.
- R8: While `fault` is 1, `paddr` is zero.
- R9: With the output register fitted (default), the result of a request presented with `req_valid` high appears after the next rising edge with `rsp_valid` high. A cycle without a request gives `rsp_valid` low, and the result outputs keep their previous values.
- R10: While `rst_n` is low and after reset, `rsp_valid`, `fault`, `fault_is_store` and `paddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| vaddr | input | 64 | Virtual address to translate |
| acc_type | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 treated as load |
| st_exl | input | 1 | Exception flag from the status register |
| st_erl | input | 1 | Error flag from the status register |
| st_mode | input | 2 | Operating-mode field from the status register |
| rsp_valid | output | 1 | Result outputs hold a fresh result |
| paddr | output | 64 | Translated physical address, zero on a fault |
| fault | output | 1 | Address error raised |
| fault_is_store | output | 1 | 1 selects the store address-error code, 0 the load code |

## Verification
The privilege check and the segment decode can both deny the same access in the same cycle. This happens when a User or Supervisor level reaches a mapped segment, for example the user-mapped low segment. Such an access must give exactly one fault, with a zero address and the code set by the access type. The bench applies these combined cases alongside cases where only one cause is present: a User access to the physical window, and a Kernel access to a mapped segment. It compares fault, code and address for each case against expected values worked out by hand. Accesses where a raised flag overrides a demoting mode field show that the privilege path alone can also clear a fault that the mode field would otherwise cause.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_SUPER  = 2'd1,
    LVL_KERNEL = 2'd2
  } priv_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  // Status fields to privilege level; raised flags force Kernel.
  function automatic priv_e mode_to_priv(input logic exl, input logic erl,
                                         input logic [1:0] mode);
    priv_e lvl;
    if (exl || erl) begin
      lvl = LVL_KERNEL;
    end else begin
      unique case (mode)
        2'b00:   lvl = LVL_KERNEL;
        2'b01:   lvl = LVL_SUPER;
        default: lvl = LVL_USER;
      endcase
    end
    return lvl;
  endfunction

  // Numeric order comparison of two levels.
  function automatic logic lvl_below(input priv_e cur, input priv_e need);
    return (2'(cur) < 2'(need));
  endfunction

  // Store code selects the store address-error; all else is a load.
  function automatic logic is_store_code(input logic [1:0] acc);
    return (acc == 2'(ACC_STORE));
  endfunction

endpackage

// File: rtl/priv_level_decode.sv
module priv_level_decode
  import vseg_pkg::*;
(
  input  logic        exl,
  input  logic        erl,
  input  logic [1:0]  mode,
  output priv_e       cur_lvl
);

  always_comb begin
    cur_lvl = mode_to_priv(exl, erl, mode);
  end

endmodule

// File: rtl/seg_map_decode.sv
module seg_map_decode
  import vseg_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int WIN_W = 59,
  parameter int CPT_W = 29
) (
  input  logic [VA_W-1:0] vaddr,
  output logic            win_sel,
  output logic            cpt_sel,
  output logic            seg_hit,
  output priv_e           req_lvl,
  output logic [VA_W-1:0] seg_pa
);

  localparam int TOP_HI  = VA_W - 1;
  localparam int TOP_LO  = VA_W - 2;
  localparam int ONES_HI = VA_W - 3;
  localparam int ONES_LO = CPT_W + 2;
  localparam int SUB_HI  = CPT_W + 1;

  logic [1:0] top_bits;
  logic       ones_ok;

  always_comb begin
    top_bits = vaddr[TOP_HI:TOP_LO];
    ones_ok  = &vaddr[ONES_HI:ONES_LO];
    win_sel  = (top_bits == 2'b10);
    // sub-select 00 or 01: only the upper sub-bit needs to be clear
    cpt_sel  = (top_bits == 2'b11) && ones_ok && !vaddr[SUB_HI];
    seg_hit  = win_sel || cpt_sel;
    req_lvl  = LVL_KERNEL;
    seg_pa   = '0;
    if (win_sel) begin
      seg_pa[WIN_W-1:0] = vaddr[WIN_W-1:0];
    end else if (cpt_sel) begin
      seg_pa[CPT_W-1:0] = vaddr[CPT_W-1:0];
    end
  end

endmodule

// File: rtl/xlate_out_stage.sv
module xlate_out_stage #(
  parameter int VA_W       = 64,
  parameter bit REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VA_W-1:0] in_pa,
  input  logic            in_fault,
  input  logic            in_st,
  output logic            out_valid,
  output logic [VA_W-1:0] out_pa,
  output logic            out_fault,
  output logic            out_st
);

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_pa    <= '0;
          out_fault <= 1'b0;
          out_st    <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_pa    <= in_pa;
            out_fault <= in_fault;
            out_st    <= in_st;
          end
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk;
      assign out_valid  = in_valid && rst_n;
      assign out_pa     = rst_n ? in_pa : '0;
      assign out_fault  = in_fault && rst_n;
      assign out_st     = in_st && rst_n;
    end
  endgenerate

endmodule

// File: rtl/vseg_translator.sv
module vseg_translator
  import vseg_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int WIN_W      = 59,
  parameter int CPT_W      = 29,
  parameter bit REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      acc_type,
  input  logic            st_exl,
  input  logic            st_erl,
  input  logic [1:0]      st_mode,
  output logic            rsp_valid,
  output logic [VA_W-1:0] paddr,
  output logic            fault,
  output logic            fault_is_store
);

  priv_e           cur_lvl;
  priv_e           req_lvl;
  logic            win_sel;
  logic            cpt_sel;
  logic            seg_hit;
  logic [VA_W-1:0] seg_pa;
  logic            priv_deny;
  logic            seg_miss;
  logic            comb_fault;
  logic            comb_st;
  logic [VA_W-1:0] comb_pa;

  priv_level_decode u_priv (
    .exl     (st_exl),
    .erl     (st_erl),
    .mode    (st_mode),
    .cur_lvl (cur_lvl)
  );

  seg_map_decode #(
    .VA_W  (VA_W),
    .WIN_W (WIN_W),
    .CPT_W (CPT_W)
  ) u_seg (
    .vaddr   (vaddr),
    .win_sel (win_sel),
    .cpt_sel (cpt_sel),
    .seg_hit (seg_hit),
    .req_lvl (req_lvl),
    .seg_pa  (seg_pa)
  );

  always_comb begin
    priv_deny  = seg_hit && lvl_below(cur_lvl, req_lvl);
    seg_miss   = !seg_hit;
    comb_fault = priv_deny || seg_miss;
    comb_st    = comb_fault && is_store_code(acc_type);
    comb_pa    = comb_fault ? '0 : seg_pa;
  end

  xlate_out_stage #(
    .VA_W       (VA_W),
    .REGISTERED (REGISTERED)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_pa     (comb_pa),
    .in_fault  (comb_fault),
    .in_st     (comb_st),
    .out_valid (rsp_valid),
    .out_pa    (paddr),
    .out_fault (fault),
    .out_st    (fault_is_store)
  );

  // R1
  flag_forces_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_exl || st_erl) |-> (cur_lvl == LVL_KERNEL));

  // R5
  one_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_sel, cpt_sel}));

  // R6
  low_level_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_hit && (cur_lvl != LVL_KERNEL)) |-> comb_fault);

  // R8
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (paddr == '0));

  // R7
  store_code_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_is_store |-> fault);

  generate
    if (REGISTERED) begin : g_reg_chk
      // R9
      req_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

      // R9
      idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

      // R9
      fault_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (fault == $past(comb_fault)));
    end
  endgenerate

endmodule

// File: tb/vseg_translator_tb.sv
`timescale 1ns/1ps
module vseg_translator_tb;

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  acc;
    logic        exl;
    logic        erl;
    logic [1:0]  mode;
    logic [63:0] pa;
    logic        flt;
    logic        st;
  } vec_t;

  localparam int NV = 19;

  // acc: 00 fetch, 01 load, 10 store, 11 reserved(load)
  // mode: 00 K, 01 S, 10 U, 11 U
  localparam vec_t VECS [NV] = '{
    '{64'h8000_0000_0000_1234, 2'b01, 1'b0, 1'b0, 2'b00, 64'h0000_0000_0000_1234, 1'b0, 1'b0}, // R3
    '{64'hB800_0000_0000_1234, 2'b00, 1'b0, 1'b0, 2'b00, 64'h0000_0000_0000_1234, 1'b0, 1'b0}, // R3 cache bits ignored
    '{64'h87FF_FFFF_FFFF_FFFF, 2'b10, 1'b0, 1'b0, 2'b00, 64'h07FF_FFFF_FFFF_FFFF, 1'b0, 1'b0}, // R3 R7 store no fault
    '{64'h8000_0000_0000_1234, 2'b01, 1'b0, 1'b0, 2'b10, 64'h0,                   1'b1, 1'b0}, // R6 user
    '{64'h8000_0000_0000_1234, 2'b10, 1'b0, 1'b0, 2'b01, 64'h0,                   1'b1, 1'b1}, // R6 R7 supervisor store
    '{64'h8000_0000_0000_1234, 2'b10, 1'b1, 1'b0, 2'b10, 64'h0000_0000_0000_1234, 1'b0, 1'b0}, // R1 exl
    '{64'h8000_0000_0000_1234, 2'b00, 1'b0, 1'b1, 2'b11, 64'h0000_0000_0000_1234, 1'b0, 1'b0}, // R1 erl
    '{64'h8000_0000_0000_1234, 2'b01, 1'b0, 1'b0, 2'b11, 64'h0,                   1'b1, 1'b0}, // R2 reserved mode
    '{64'hFFFF_FFFF_8000_0010, 2'b01, 1'b0, 1'b0, 2'b00, 64'h0000_0000_0000_0010, 1'b0, 1'b0}, // R4 sub 00
    '{64'hFFFF_FFFF_BFFF_FFFF, 2'b10, 1'b0, 1'b0, 2'b00, 64'h0000_0000_1FFF_FFFF, 1'b0, 1'b0}, // R4 sub 01
    '{64'hFFFF_FFFF_C000_0000, 2'b10, 1'b0, 1'b0, 2'b00, 64'h0,                   1'b1, 1'b1}, // R5 sub 10
    '{64'hFFFF_FFFF_E000_0000, 2'b11, 1'b0, 1'b0, 2'b00, 64'h0,                   1'b1, 1'b0}, // R5 R7 sub 11 rsvd acc
    '{64'hC000_0000_0000_0000, 2'b01, 1'b0, 1'b0, 2'b00, 64'h0,                   1'b1, 1'b0}, // R5 top 11 not ones
    '{64'hFFFF_FFFF_7FFF_FFFF, 2'b00, 1'b0, 1'b0, 2'b00, 64'h0,                   1'b1, 1'b0}, // R5 bit31 clear
    '{64'h4000_0000_0000_0000, 2'b10, 1'b0, 1'b0, 2'b00, 64'h0,                   1'b1, 1'b1}, // R5 top 01
    '{64'h0000_0000_0000_1000, 2'b01, 1'b0, 1'b0, 2'b10, 64'h0,                   1'b1, 1'b0}, // R5 R6 user + mapped
    '{64'hFFFF_FFFF_8000_0010, 2'b00, 1'b0, 1'b0, 2'b01, 64'h0,                   1'b1, 1'b0}, // R6 R2 supervisor compat
    '{64'h0000_0000_0000_1000, 2'b10, 1'b0, 1'b0, 2'b00, 64'h0,                   1'b1, 1'b1}, // R5 kernel mapped store
    '{64'hFFFF_FFFF_A000_0004, 2'b01, 1'b0, 1'b1, 2'b10, 64'h0000_0000_0000_0004, 1'b0, 1'b0}  // R1 R4
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] vaddr;
  logic [1:0]  acc_type;
  logic        st_exl;
  logic        st_erl;
  logic [1:0]  st_mode;
  logic        rsp_valid;
  logic [63:0] paddr;
  logic        fault;
  logic        fault_is_store;

  int n_chk;
  int n_bad;
  bit done;

  vseg_translator u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .vaddr          (vaddr),
    .acc_type       (acc_type),
    .st_exl         (st_exl),
    .st_erl         (st_erl),
    .st_mode        (st_mode),
    .rsp_valid      (rsp_valid),
    .paddr          (paddr),
    .fault          (fault),
    .fault_is_store (fault_is_store)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {valid,fault,st,pa}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int w = 0; w < 20000; w++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; vaddr = '0; acc_type = '0;
    st_exl = 1'b0; st_erl = 1'b0; st_mode = '0;
    repeat (3) @(negedge clk);
    // R10 outputs held at zero in reset
    check("R10 in reset", {rsp_valid, fault, fault_is_store, paddr}, 67'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", {rsp_valid, fault, fault_is_store, paddr}, 67'h0);

    for (int i = 0; i < NV; i++) begin
      vaddr = VECS[i].va; acc_type = VECS[i].acc;
      st_exl = VECS[i].exl; st_erl = VECS[i].erl; st_mode = VECS[i].mode;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      $display("vector %0d", i);
      check("R1..R8 vector", {rsp_valid, fault, fault_is_store, paddr},
            {1'b1, VECS[i].flt, VECS[i].st, VECS[i].pa});
    end

    // R9 idle cycle: valid drops, result held (last vector pa = 4)
    vaddr = 64'h8000_0000_0000_BEEF; st_mode = 2'b00;
    @(negedge clk);
    check("R9 idle hold", {rsp_valid, fault, fault_is_store, paddr},
          {1'b0, 1'b0, 1'b0, 64'h4});

    // R9 back-to-back requests: each result one cycle later
    req_valid = 1'b1; acc_type = 2'b10; vaddr = 64'h4000_0000_0000_0000;
    @(negedge clk);
    check("R9 b2b first", {rsp_valid, fault, fault_is_store, paddr}, {3'b111, 64'h0});
    vaddr = 64'hFFFF_FFFF_8000_0020; acc_type = 2'b01;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 b2b second", {rsp_valid, fault, fault_is_store, paddr}, {3'b100, 64'h20});

    // R10 mid-run reset after a faulting store
    req_valid = 1'b1; vaddr = 64'h0; acc_type = 2'b10;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 store fault pre-reset", {rsp_valid, fault, fault_is_store, paddr}, {3'b111, 64'h0});
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid reset", {rsp_valid, fault, fault_is_store, paddr}, 67'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule